// File: doc/BRIEF.md
# Oscillator Warm-Up Timer Controller

This block counts oscillator cycles so that software can wait for a crystal to settle before it moves the system between the fast and the slow clock source. Software chooses one of four warm-up lengths with a two-bit code and launches the count by writing a one to a start bit. The same bit reads back as one while the count runs and drops to zero on its own when the count ends. Software polls it to learn that the oscillator may be used. A start request is refused while the external PLL-lock indication is high.

The block runs entirely from the oscillator clock. It also keeps the configuration that the clock divider uses after reset, and it produces two clock-enable strobes. The reference strobe is high on every second oscillator cycle by default, which halves the rate, or on every cycle when the halving stage is bypassed. The system strobe picks one reference pulse out of every 1, 2, 4 or 8 pulses, according to a gear code. After reset the gear is 8.

Registers are reached through a plain synchronous bus: a write strobe, a two-bit register address, 32-bit write data and a combinational 32-bit read word.

Top module: `osc_warmup_ctrl`

## Requirements
- R1: While reset is held, and just after it ends, register 0 reads 0x0000_0000 and register 1 reads 0x0000_0303 (length code 11, halving active, gear code 11).
- R2: A write to register 0 with bit 0 set, while idle and with `pll_locked` low, makes register 0 bit 0 read 1 from the next cycle.
- R3: Once started, bit 0 stays 1 for exactly N oscillator cycles and then reads 0. N is 1 for length code 00, 2^8 for code 01, 2^14 for code 10 and 2^16 for code 11. The length code is register 1 bits [1:0].
- R4: The length code is captured when a start is accepted. Writing register 1 during a count leaves that count's length unchanged.
- R5: Writing 0 to register 0 bit 0 has no effect. Writing 1 during a count does not restart it, and the count continues to decrement.
- R6: A start write while `pll_locked` is high is ignored, and bit 0 stays 0.
- R7: With register 1 bit 4 (bypass) at 0, `ref_ce` is high on alternate oscillator cycles, 64 times in any 128 cycles. With bypass at 1, `ref_ce` is high on every cycle.
- R8: `sys_ce` is high only together with `ref_ce`, once for every 2^g `ref_ce` pulses, where g is register 1 bits [9:8]. The reset gear gives one pulse per 8.
- R9: A write to register 1 stores bits [1:0], 4 and [9:8]. All other bits of register 1 read 0. Register 0 bits [31:1] read 0, and addresses 2 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock; every register uses it |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 control, 1 configuration |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| pll_locked | input | 1 | PLL lock indication; a start is refused while high |
| ref_ce | output | 1 | Reference clock-enable strobe (halved or full rate) |
| sys_ce | output | 1 | System clock-enable strobe after the gear divider |

## Verification
On every cycle the assertions check the following. An accepted start raises the busy state. A set lock flag keeps an idle timer idle. A running count moves down by exactly one per cycle, so it is never reloaded. Busy falls only from a count of zero. The reference strobe alternates when not bypassed, and the system strobe never appears without a reference pulse. The overall warm-up lengths for each code depend on a whole count history, and only the bench scenarios can show them. The same holds for the rule that a mid-count configuration write does not change the length, and for the pulse totals over fixed windows for each gear and bypass setting. The bench also compares read data and both strobes against its behavioural model on every cycle.

// File: rtl/owc_pkg.sv
package owc_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int SHORT_EXP = 8;
    localparam int MID_EXP   = 14;
    localparam int LONG_EXP  = 16;
    localparam int GEAR_W    = 2;
    localparam int GCNT_W    = (1 << GEAR_W) - 1;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_CFG  = ADDR_W'(1);

    localparam int CTRL_START_BIT = 0;
    localparam int CFG_SEL_LSB    = 0;
    localparam int CFG_BYP_BIT    = 4;
    localparam int CFG_GEAR_LSB   = 8;

    typedef enum logic [1:0] {
        WU_IMM   = 2'b00,
        WU_SHORT = 2'b01,
        WU_MID   = 2'b10,
        WU_LONG  = 2'b11
    } wu_len_e;

    typedef enum logic [GEAR_W-1:0] {
        GEAR_1 = 2'd0,
        GEAR_2 = 2'd1,
        GEAR_4 = 2'd2,
        GEAR_8 = 2'd3
    } gear_e;

    typedef struct packed {
        gear_e   gear;
        logic    bypass;
        wu_len_e len;
    } clk_cfg_t;

    localparam clk_cfg_t CFG_RESET = '{gear: GEAR_8, bypass: 1'b0, len: WU_LONG};

    function automatic logic [DATA_W-1:0] cfg_to_word(clk_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CFG_SEL_LSB +: 2]       = c.len;
        w[CFG_BYP_BIT]            = c.bypass;
        w[CFG_GEAR_LSB +: GEAR_W] = c.gear;
        return w;
    endfunction

    function automatic clk_cfg_t word_to_cfg(logic [DATA_W-1:0] w);
        clk_cfg_t c;
        c.len    = wu_len_e'(w[CFG_SEL_LSB +: 2]);
        c.bypass = w[CFG_BYP_BIT];
        c.gear   = gear_e'(w[CFG_GEAR_LSB +: GEAR_W]);
        return c;
    endfunction

    function automatic logic [GCNT_W-1:0] gear_mask(gear_e g);
        return GCNT_W'((1 << g) - 1);
    endfunction

endpackage

// File: rtl/owc_regs.sv
module owc_regs
    import owc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          busy,
    output clk_cfg_t      cfg,
    output logic          start_req,
    output logic [DW-1:0] rdata
);

    clk_cfg_t cfg_q;
    logic     wr_cfg;

    assign wr_cfg    = we && (addr == AW'(ADDR_CFG));
    assign start_req = we && (addr == AW'(ADDR_CTRL)) && wdata[CTRL_START_BIT];
    assign cfg       = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (wr_cfg) begin
            cfg_q <= word_to_cfg(DATA_W'(wdata));
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            AW'(ADDR_CTRL): rdata[CTRL_START_BIT] = busy;
            AW'(ADDR_CFG):  rdata = DW'(cfg_to_word(cfg_q));
            default:        rdata = '0;
        endcase
    end

endmodule

// File: rtl/owc_timer.sv
module owc_timer
    import owc_pkg::*;
#(
    parameter int S_EXP = SHORT_EXP,
    parameter int M_EXP = MID_EXP,
    parameter int L_EXP = LONG_EXP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic             pll_locked,
    input  wu_len_e          len,
    output logic             busy,
    output logic [L_EXP-1:0] left
);

    localparam int CNT_W = L_EXP;
    localparam logic [CNT_W-1:0] RELOAD_S = CNT_W'((64'd1 << S_EXP) - 64'd1);
    localparam logic [CNT_W-1:0] RELOAD_M = CNT_W'((64'd1 << M_EXP) - 64'd1);
    localparam logic [CNT_W-1:0] RELOAD_L = CNT_W'((64'd1 << L_EXP) - 64'd1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;
    logic             accept;

    always_comb begin
        case (len)
            WU_SHORT: reload = RELOAD_S;
            WU_MID:   reload = RELOAD_M;
            WU_LONG:  reload = RELOAD_L;
            default:  reload = '0;
        endcase
    end

    assign accept = start_req && !busy_q && !pll_locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (accept) begin
            busy_q <= 1'b1;
            cnt_q  <= reload;
        end
    end

    assign busy = busy_q;
    assign left = cnt_q;

endmodule

// File: rtl/owc_clkgen.sv
module owc_clkgen
    import owc_pkg::*;
#(
    parameter int GW = GCNT_W
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  bypass,
    input  gear_e gear,
    output logic  ref_ce,
    output logic  sys_ce
);

    logic          phase_q;
    logic [GW-1:0] gcnt_q;
    logic [GW-1:0] mask;

    assign mask   = GW'(gear_mask(gear));
    assign ref_ce = bypass | phase_q;
    assign sys_ce = ref_ce && ((gcnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            gcnt_q  <= '0;
        end else begin
            phase_q <= ~phase_q;
            if (ref_ce) begin
                gcnt_q <= gcnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/osc_warmup_ctrl.sv
module osc_warmup_ctrl
    import owc_pkg::*;
#(
    parameter int S_EXP = SHORT_EXP,
    parameter int M_EXP = MID_EXP,
    parameter int L_EXP = LONG_EXP
) (
    input  logic              clk_osc,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pll_locked,
    output logic              ref_ce,
    output logic              sys_ce
);

    clk_cfg_t         cfg_q;
    logic             start_req;
    logic             warm_busy;
    logic [L_EXP-1:0] warm_left;

    owc_regs #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk       (clk_osc),
        .rst       (rst),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .busy      (warm_busy),
        .cfg       (cfg_q),
        .start_req (start_req),
        .rdata     (bus_rdata)
    );

    owc_timer #(.S_EXP(S_EXP), .M_EXP(M_EXP), .L_EXP(L_EXP)) u_timer (
        .clk        (clk_osc),
        .rst        (rst),
        .start_req  (start_req),
        .pll_locked (pll_locked),
        .len        (cfg_q.len),
        .busy       (warm_busy),
        .left       (warm_left)
    );

    owc_clkgen #(.GW(GCNT_W)) u_clkgen (
        .clk    (clk_osc),
        .rst    (rst),
        .bypass (cfg_q.bypass),
        .gear   (cfg_q.gear),
        .ref_ce (ref_ce),
        .sys_ce (sys_ce)
    );

endmodule

// File: rtl/owc_chk.sv
module owc_chk
    import owc_pkg::*;
#(
    parameter int CW = LONG_EXP
) (
    input logic              clk,
    input logic              rst,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              pll_locked,
    input logic              busy,
    input logic [CW-1:0]     left,
    input logic              bypass,
    input logic              ref_ce,
    input logic              sys_ce
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> !busy);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == ADDR_CTRL && wdata[CTRL_START_BIT] && !busy && !pll_locked) |=> busy);

    // R6
    lock_block_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && pll_locked) |=> !busy);

    // R5
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && left != '0) |=> (busy && left == $past(left) - 1'b1));

    // R3
    expire_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(left) == '0));

    // R7
    ref_alternate_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_ce && !bypass) |=> (ref_ce == bypass));

    // R7
    ref_bypass_chk: assert property (@(posedge clk) disable iff (rst)
        bypass |-> ref_ce);

    // R8
    sys_in_ref_chk: assert property (@(posedge clk) disable iff (rst)
        sys_ce |-> ref_ce);

endmodule

bind osc_warmup_ctrl owc_chk #(.CW(L_EXP)) u_owc_chk (
    .clk        (clk_osc),
    .rst        (rst),
    .we         (bus_we),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .pll_locked (pll_locked),
    .busy       (warm_busy),
    .left       (warm_left),
    .bypass     (cfg_q.bypass),
    .ref_ce     (ref_ce),
    .sys_ce     (sys_ce)
);

// File: tb/test_osc_warmup_ctrl.sv
`timescale 1ns/1ps
module test_osc_warmup_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'd0;
    logic        lock = 1'b0;
    wire  [31:0] rdata;
    wire         ref_ce;
    wire         sys_ce;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // behavioural reference state
    bit m_busy;
    int m_left;
    int m_sel;
    int m_byp;
    int m_gear;
    bit m_ph;
    int m_nref;
    bit m_refnow;
    bit cmp_on = 1'b0;

    osc_warmup_ctrl i_osc_warmup_ctrl (
        .clk_osc    (clk),
        .rst        (rst),
        .bus_we     (we),
        .bus_addr   (addr),
        .bus_wdata  (wdata),
        .bus_rdata  (rdata),
        .pll_locked (lock),
        .ref_ce     (ref_ce),
        .sys_ce     (sys_ce)
    );

    always #2.5 clk = ~clk;

    function automatic int len_of(int code);
        case (code)
            0: return 1;
            1: return 256;
            2: return 16384;
            default: return 65536;
        endcase
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 190000);
            summary_and_end();
        end
        if (rst) begin
            m_busy = 0; m_left = 0; m_sel = 3; m_byp = 0; m_gear = 3;
            m_ph = 0; m_nref = 0;
        end else begin
            m_refnow = (m_byp != 0) || m_ph;
            if (m_refnow) m_nref++;
            m_ph = !m_ph;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) m_busy = 0;
            end else if (we && addr == 2'd0 && wdata[0] === 1'b1 && !lock) begin
                m_busy = 1;
                m_left = len_of(m_sel);
            end
            if (we && addr == 2'd1) begin
                m_sel  = int'(wdata[1:0]);
                m_byp  = int'(wdata[4]);
                m_gear = int'(wdata[9:8]);
            end
        end
    end

    // per-cycle comparison, away from the clock edge
    always @(negedge clk) begin
        #1;
        if (cmp_on && !rst) begin
            bit e_ref;
            bit e_sys;
            int per;
            logic [31:0] e_rd;
            e_ref = (m_byp != 0) || m_ph;
            per   = 1 << m_gear;
            e_sys = e_ref && ((m_nref % per) == per - 1);
            case (addr)
                2'd0: e_rd = {31'd0, m_busy};
                2'd1: e_rd = {22'd0, 2'(m_gear), 3'd0, 1'(m_byp), 2'd0, 2'(m_sel)};
                default: e_rd = 32'd0;
            endcase
            chk("R7", "ref_ce model", ref_ce, e_ref);
            chk("R8", "sys_ce model", sys_ce, e_sys);
            chk("R9", "rdata model", rdata, e_rd);
        end
    end

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = 32'd0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    // count ref/sys pulses over n cycles
    task automatic window(int n, output int nr, output int ns);
        nr = 0; ns = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            if (ref_ce) nr++;
            if (sys_ce) ns++;
        end
    endtask

    // cycles from accepted start edge until busy reads 0
    task automatic wait_idle(int c0, output int n);
        addr = 2'd0;
        #1;
        while (rdata[0] === 1'b1) begin
            @(negedge clk);
            #1;
        end
        n = cyc - c0;
    endtask

    task automatic measure(int code, string req);
        int c0;
        int n;
        wr(2'd1, 32'h300 | 32'(code));
        wr(2'd0, 32'd1);
        c0 = cyc;
        addr = 2'd0;
        #1 chk("R2", "busy after start", rdata[0], 1);
        wait_idle(c0, n);
        chk(req, $sformatf("warm-up length code %0d", code), n, len_of(code));
    endtask

    initial begin
        logic [31:0] v;
        int nr;
        int ns;
        int c0;
        int n;

        repeat (4) @(negedge clk);
        // R1: reset state while reset is held
        addr = 2'd0;
        #1 chk("R1", "ctrl during reset", rdata, 32'h0);
        addr = 2'd1;
        #1 chk("R1", "cfg during reset", rdata, 32'h303);
        @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        rd(2'd0, v); chk("R1", "ctrl after reset", v, 32'h0);
        rd(2'd1, v); chk("R1", "cfg after reset", v, 32'h303);

        // R8: default gear and halving
        window(128, nr, ns);
        chk("R7", "ref pulses halved", nr, 64);
        chk("R8", "sys pulses default gear 8", ns, 8);

        // R9: field storage and unmapped space
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R9", "cfg all ones", v, 32'h313);
        rd(2'd2, v); chk("R9", "address 2", v, 32'h0);
        rd(2'd3, v); chk("R9", "address 3", v, 32'h0);
        rd(2'd0, v); chk("R9", "ctrl upper bits", v, 32'h0);

        // R7 and R8 over other settings
        wr(2'd1, 32'h211);
        window(64, nr, ns);
        chk("R7", "ref pulses bypass", nr, 64);
        chk("R8", "sys pulses gear 4", ns, 16);
        wr(2'd1, 32'h001);
        window(64, nr, ns);
        chk("R7", "ref pulses halved gear 1", nr, 32);
        chk("R8", "sys pulses gear 1", ns, 32);
        wr(2'd1, 32'h110);
        window(64, nr, ns);
        chk("R8", "sys pulses gear 2 bypass", ns, 32);

        // R5: writing 0 while idle does nothing
        wr(2'd1, 32'h301);
        wr(2'd0, 32'hFFFF_FFFE);
        rd(2'd0, v); chk("R5", "write 0 idle", v, 32'h0);

        // R3: every length code
        measure(0, "R3");
        measure(1, "R3");
        measure(2, "R3");
        measure(3, "R3");

        // R4: length captured at start
        wr(2'd1, 32'h301);
        wr(2'd0, 32'd1);
        c0 = cyc;
        wr(2'd1, 32'h303);
        wait_idle(c0, n);
        chk("R4", "length after cfg write mid-count", n, 256);
        rd(2'd1, v); chk("R4", "new code stored", v, 32'h303);

        // R5: no restart, no effect of 0
        wr(2'd1, 32'h301);
        wr(2'd0, 32'd1);
        c0 = cyc;
        repeat (50) @(negedge clk);
        wr(2'd0, 32'd0);
        wr(2'd0, 32'd1);
        wait_idle(c0, n);
        chk("R5", "no restart during count", n, 256);

        // R6: lock blocks start
        lock = 1'b1;
        wr(2'd0, 32'd1);
        rd(2'd0, v); chk("R6", "start refused while locked", v, 32'h0);
        repeat (5) @(negedge clk);
        rd(2'd0, v); chk("R6", "still idle while locked", v, 32'h0);
        lock = 1'b0;
        measure(0, "R3");

        repeat (4) @(negedge clk);
        cmp_on = 1'b0;
        summary_and_end();
    end

endmodule